// File: doc/BRIEF.md
# Two-List Common Value Finder

This block takes in two lists of bytes on one byte-wide stream and reports the one value the two lists share. The first LEN_A accepted bytes form list A and are kept in on-chip registers. Each of the next LEN_B accepted bytes, which form list B, is checked against all stored list A entries in the same cycle it arrives. No search pass runs after loading, so the answer is ready one cycle after the last list B byte. By default list A has 20 entries and list B has 30. A plain serial search would need up to 600 compare cycles.

The block assumes the lists share at most one value. It keeps a single result register and a `found` flag, so a shared value of zero can be told apart from "nothing shared". A `start` pulse clears the block for a new pair of lists. `done` marks the cycle in which the answer becomes valid. The answer stays in place until the next `start`. If a second match shows up even though the lists should not allow it, the first match is kept and `error` is raised.

Top module: `isect_finder`

## Requirements
- R1: While reset is low and right after it is released, `result` is 0 and `found`, `done` and `error` are 0.
- R2: The first LEN_A bytes accepted (with `inValid` high) after a start or reset form list A, and the next LEN_B form list B. When a list B byte equals any list A entry, `result` takes that byte and `found` goes to 1.
- R3: When no list B byte equals any list A entry, `result` is 0 and `found` is 0 at `done`.
- R4: A shared value of 0 is reported as `result` 0 with `found` 1.
- R5: `done` is high for exactly one cycle: the cycle after the last of the LEN_A+LEN_B accepted bytes. Cycles with `inValid` low are not counted.
- R6: After `done`, `result`, `found` and `error` hold their values until the next `start`. Bytes that arrive after the last list B byte change nothing and do not raise `done` again.
- R7: `start` clears `result`, `found`, `error`, `done` and the byte count in the next cycle. A byte presented in the same cycle as `start` is dropped.
- R8: If more than one list B byte matches, `result` keeps the first matching value and `error` goes to 1.
- R9: A value that appears twice in list A and once in list B counts as one match and does not raise `error`.
- R10: A match is found in every pair of positions, including the first and last entries of both lists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clears all state for a new pair of lists |
| inValid | input | 1 | Qualifies `inData` this cycle |
| inData | input | DATA_W | Incoming list byte |
| result | output | DATA_W | Shared value, 0 when none |
| found | output | 1 | A shared value was captured |
| done | output | 1 | One-cycle pulse when the answer is valid |
| error | output | 1 | More than one match was seen |

## Verification
Two things can happen in the same clock edge: the compare that finds a match on the final list B byte, and the `done` pulse that comes from that same byte. The sweep places the shared value at every list A position against every list B position, so the case where the match lands on the last byte is covered. Each run checks that `result`, `found` and `done` all appear in the cycle after that byte. A second pair of coincident events, a `start` presented together with a valid byte, is produced by placing the shared value in the last list A slot. If the dropped byte were counted, the lists would shift by one and the match would be lost.

// File: rtl/isect_pkg.sv
package isect_pkg;
  typedef struct packed {
    logic clear;   // wipe stored list and result
    logic storeA;  // shift current byte into list A
    logic cmpB;    // compare current byte against list A
    logic last;    // current byte is the final list B entry
  } isectCtl_t;
endpackage

// File: rtl/isect_ctrl.sv
module isect_ctrl
  import isect_pkg::*;
#(
  parameter int LEN_A = 20,
  parameter int LEN_B = 30
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      inValid,
  output isectCtl_t ctl,
  output logic      done
);
  localparam int TOTAL = LEN_A + LEN_B;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] byteCnt;
  logic inA;
  logic inB;

  always_comb begin
    inA        = byteCnt < CNT_W'(LEN_A);
    inB        = !inA && (byteCnt < CNT_W'(TOTAL));
    ctl.clear  = start;
    ctl.storeA = !start && inValid && inA;
    ctl.cmpB   = !start && inValid && inB;
    ctl.last   = ctl.cmpB && (byteCnt == CNT_W'(TOTAL - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= ctl.last;
      if (start)                        byteCnt <= '0;
      else if (ctl.storeA || ctl.cmpB)  byteCnt <= byteCnt + 1'b1;
    end
  end
endmodule

// File: rtl/isect_datapath.sv
module isect_datapath
  import isect_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_A  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  isectCtl_t         ctl,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] result,
  output logic              found,
  output logic              error
);
  logic [DATA_W-1:0] listA [LEN_A];
  logic [LEN_A-1:0]  hitVec;
  logic              anyHit;

  for (genvar i = 0; i < LEN_A; i++) begin : gSlot
    logic [DATA_W-1:0] nextVal;
    if (i == 0) begin : gHead
      assign nextVal = inData;
    end else begin : gBody
      assign nextVal = listA[i-1];
    end

    always_ff @(posedge clk) begin
      if (!rstN || ctl.clear) listA[i] <= '0;
      else if (ctl.storeA)    listA[i] <= nextVal;
    end

    assign hitVec[i] = (listA[i] == inData);
  end

  assign anyHit = ctl.cmpB && (|hitVec);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      result <= '0;
      found  <= 1'b0;
      error  <= 1'b0;
    end else if (anyHit) begin
      if (!found) begin
        result <= inData;
        found  <= 1'b1;
      end else begin
        error  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/isect_finder.sv
module isect_finder
  import isect_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_A  = 20,
  parameter int LEN_B  = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] result,
  output logic              found,
  output logic              done,
  output logic              error
);
  isectCtl_t ctl;

  isect_ctrl #(.LEN_A(LEN_A), .LEN_B(LEN_B)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .ctl(ctl), .done(done)
  );

  isect_datapath #(.DATA_W(DATA_W), .LEN_A(LEN_A)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData),
    .result(result), .found(found), .error(error)
  );
endmodule

// File: rtl/isect_checker.sv
module isect_checker #(
  parameter int DATA_W = 8,
  parameter int LEN_A  = 20,
  parameter int LEN_B  = 30
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic [DATA_W-1:0] result,
  input logic              found,
  input logic              done,
  input logic              error
);
  localparam int TOTAL = LEN_A + LEN_B;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] seenCnt;
  logic             complete;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenCnt  <= '0;
      complete <= 1'b0;
    end else if (start) begin
      seenCnt  <= '0;
      complete <= 1'b0;
    end else begin
      if (inValid && seenCnt < CNT_W'(TOTAL)) seenCnt <= seenCnt + 1'b1;
      if (done) complete <= 1'b1;
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    done |-> seenCnt == CNT_W'(TOTAL)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5
  AST_NOFOUND_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !found |-> result == '0); // R3
  AST_FOUND_IN_B: assert property (@(posedge clk) disable iff (!rstN)
    $rose(found) |-> seenCnt > CNT_W'(LEN_A)); // R2
  AST_ERROR_NEEDS_FOUND: assert property (@(posedge clk) disable iff (!rstN)
    error |-> found); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!found && !error && !done && result == '0)); // R7
  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (complete && !start) |=> ($stable(result) && $stable(found) && $stable(error))); // R6
endmodule

bind isect_finder isect_checker #(.DATA_W(DATA_W), .LEN_A(LEN_A), .LEN_B(LEN_B)) uChk (.*);

// File: tb/tb_isect_finder.sv
module tb_isect_finder;
  localparam int DW = 8;
  localparam int LA = 20;
  localparam int LB = 30;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic [DW-1:0] result;
  logic          found;
  logic          done;
  logic          error;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] aVals [LA];
  logic [DW-1:0] bVals [LB];

  always #5 clk = ~clk;

  isect_finder #(.DATA_W(DW), .LEN_A(LA), .LEN_B(LB)) dut (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inData(inData),
    .result(result), .found(found), .done(done), .error(error)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // list A: 3i+1 (1..58); list B: 128+4j (128..244); disjoint
  task automatic fillBase();
    for (int i = 0; i < LA; i++) aVals[i] = DW'(i * 3 + 1);
    for (int j = 0; j < LB; j++) bVals[j] = DW'(128 + j * 4);
  endtask

  task automatic pulseStart(input logic withByte);
    @(negedge clk);
    start = 1'b1; inValid = withByte; inData = aVals[0];
    @(negedge clk);
    start = 1'b0; inValid = 1'b0;
    check("R7 clear result", result, 0);
    check("R7 clear found", found, 0);
    check("R7 clear error", error, 0);
    check("R7 clear done", done, 0);
  endtask

  task automatic feed(input logic [DW-1:0] v, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); inValid = 1'b0; inData = 8'hEE;
    end
    @(negedge clk); inValid = 1'b1; inData = v;
  endtask

  task automatic runLists(input int gap, input logic [DW-1:0] expRes,
                          input logic expFound, input logic expErr, input string tag);
    for (int i = 0; i < LA; i++) feed(aVals[i], (i % 3 == 0) ? gap : 0);
    for (int j = 0; j < LB; j++) feed(bVals[j], (j % 3 == 0) ? gap : 0);
    check({tag, " R5 done not early"}, done, 0);
    @(negedge clk); inValid = 1'b0;
    check({tag, " R5 done"}, done, 1);
    check({tag, " result"}, result, expRes);
    check({tag, " found"}, found, expFound);
    check({tag, " error"}, error, expErr);
    @(negedge clk);
    check({tag, " R5 done single"}, done, 0);
    check({tag, " R6 hold"}, result, expRes);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    fillBase();
    repeat (3) @(negedge clk);
    check("R1 result in reset", result, 0);
    check("R1 flags in reset", {found, done, error}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 result after reset", result, 0);
    check("R1 flags after reset", {found, done, error}, 0);

    // R2 / R10: every position pair
    for (int ia = 0; ia < LA; ia++) begin
      for (int ib = 0; ib < LB; ib++) begin
        fillBase();
        bVals[ib] = aVals[ia];
        pulseStart(1'b0);
        runLists(0, DW'(ia * 3 + 1), 1'b1, 1'b0, "R2/R10 sweep");
      end
    end

    // R3: no shared value
    fillBase();
    pulseStart(1'b0);
    runLists(0, 0, 1'b0, 1'b0, "R3 none");

    // R4: shared value zero
    fillBase();
    aVals[5] = 0; bVals[7] = 0;
    pulseStart(1'b0);
    runLists(0, 0, 1'b1, 1'b0, "R4 zero");

    // R8: two matches, first kept
    fillBase();
    bVals[3] = aVals[2]; bVals[10] = aVals[8];
    pulseStart(1'b0);
    runLists(0, DW'(2 * 3 + 1), 1'b1, 1'b1, "R8 double");

    // R9: duplicate inside list A
    fillBase();
    aVals[4] = 8'h77; aVals[9] = 8'h77; bVals[6] = 8'h77;
    pulseStart(1'b0);
    runLists(0, 8'h77, 1'b1, 1'b0, "R9 dupA");

    // R5: idle gaps in the stream
    fillBase();
    bVals[17] = aVals[11];
    pulseStart(1'b0);
    runLists(2, DW'(11 * 3 + 1), 1'b1, 1'b0, "R5 gaps");

    // R6: extra bytes after the last one
    for (int k = 0; k < 4; k++) begin
      feed((k % 2 == 0) ? aVals[0] : aVals[11], 0);
      check("R6 no second done", done, 0);
    end
    @(negedge clk); inValid = 1'b0;
    check("R6 result held", result, DW'(11 * 3 + 1));
    check("R6 found held", found, 1);
    check("R6 error held", error, 0);
    check("R6 done stays low", done, 0);

    // R7: byte together with start is dropped
    fillBase();
    bVals[12] = aVals[LA-1];
    pulseStart(1'b1);
    runLists(0, DW'((LA - 1) * 3 + 1), 1'b1, 1'b0, "R7 start+byte");

    // R7: abort part-way and reload
    fillBase();
    pulseStart(1'b0);
    for (int k = 0; k < 10; k++) feed(bVals[k], 0);
    bVals[0] = aVals[0];
    pulseStart(1'b0);
    runLists(0, DW'(1), 1'b1, 1'b0, "R7 abort");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule